// File: doc/BRIEF.md
# Six-Channel Timer Unit with Interrupt Capture

This peripheral holds six down-counting timers behind a small synchronous register port that takes 32-bit accesses. The timers are arranged as three identical pairs. Each pair occupies a 32-byte window, the first window beginning at offset 0x10, and the second timer of a pair sits four bytes above the first. Every timer has four registers: a control word, a run word, a reload value and a live count.

While a timer runs, it counts down once per clock. When it passes through zero, it records a sticky capture bit and reloads itself. The capture bits live in one shared register. Software clears them by writing ones to that register, and a separate enable mask routes them onto six interrupt lines, one for each timer.

A global clock-control word decides whether the core counts at all. Three conditions must hold together: the disable bit is clear, the suspend-release bit is set and the run-mode bit is set.

Top module: `tmr6_unit`

## Requirements
- R1: After synchronous reset, every writable register reads zero, all capture bits are clear, all interrupt outputs are low and every count reads zero.
- R2: Timer n (0..5) has its base at (n>>1)*0x20 + 0x10, plus 4 when n is odd. Control sits at base+0x00, run at base+0x08, reload at base+0x10 and count at base+0x18. Reads of any offset not in the register map return zero. Writes to such offsets change nothing.
- R3: The clock-control word is at 0x00 and reads back bits 0, 4 and 8. Timers count only while bit 0 is 0, bit 4 is 1 and bit 8 is 1. Otherwise every count holds its value.
- R4: Writing the run word with bit 2 set loads the count from reload on the next clock edge, whether or not the core is counting. Bit 2 then reads back 0, while run bit 0 keeps its written value.
- R5: A timer counts only while its run bit 0 is set and the core is counting. On each clock it decrements by one. From zero it reloads instead and raises its capture bit, so the event period is reload+1 clocks.
- R6: Writing zero to the run word stops the timer, and its count then holds.
- R7: The capture register is at 0xFC and bit n belongs to timer n. Writing a 1 to a bit clears it, and writing 0 leaves it alone. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R8: The interrupt-enable register is at 0xF4. Output irq_o[n] equals capture bit n AND enable bit n, so writing zero masks all six outputs.
- R9: The count register is read-only. The control word stores bits 10:0 and reads them back without affecting counting. The interrupt-control word at 0xF8 stores bits 5:0 and reads them back.
- R10: The identification word at 0x08 reads 0x00005900 (bits 15:8 = 0x59) and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 6 | Per-timer interrupt lines |

## Verification
The hardest case to reach from the ports is an expiry that lands in exactly the same cycle as a write-one-to-clear of that timer's capture bit. The stimulus builds it with a reload value of 1, which makes the expiry edges fall on every second edge at a known phase after the start write. It then issues clears back to back so that one clear coincides with an expiry and the next does not. Random trials over timer index, reload value, elapsed cycles and enable mask then compare the live count, the capture bits and the interrupt lines against a closed-form model of the count period.

// File: rtl/tmr6_pkg.sv
package tmr6_pkg;

    localparam int NTMR     = 6;
    localparam int CTL_W    = 11;
    localparam logic [7:0] ID_CODE = 8'h59;

    localparam logic [7:0] OFS_CLK = 8'h00;
    localparam logic [7:0] OFS_ID  = 8'h08;
    localparam logic [7:0] OFS_IEN = 8'hF4;
    localparam logic [7:0] OFS_ICR = 8'hF8;
    localparam logic [7:0] OFS_CAP = 8'hFC;
    localparam logic [7:0] TMR_LO  = 8'h10;
    localparam logic [7:0] TMR_HI  = 8'h70;

    typedef enum logic [2:0] {
        SP_NONE, SP_CLK, SP_ID, SP_IEN, SP_ICR, SP_CAP, SP_TMR
    } space_e;

    typedef enum logic [1:0] {
        K_CTL = 2'd0, K_RUN = 2'd1, K_RLD = 2'd2, K_CNT = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        space_e   space;
        logic [2:0] idx;
        tmr_reg_e kind;
    } sel_t;

    typedef struct packed {
        logic runm;
        logic susp_rel;
        logic dis;
    } clkctl_t;

    function automatic sel_t decode(input logic [7:0] a, input logic hi_ok);
        sel_t s;
        logic [7:0] r;
        s.space = SP_NONE;
        s.idx   = '0;
        s.kind  = K_CTL;
        r = a - TMR_LO;
        if (hi_ok && a[1:0] == 2'b00) begin
            case (a)
                OFS_CLK: s.space = SP_CLK;
                OFS_ID:  s.space = SP_ID;
                OFS_IEN: s.space = SP_IEN;
                OFS_ICR: s.space = SP_ICR;
                OFS_CAP: s.space = SP_CAP;
                default: begin
                    if (a >= TMR_LO && a < TMR_HI) begin
                        s.space = SP_TMR;
                        s.idx   = {r[6:5], r[2]};
                        s.kind  = tmr_reg_e'(r[4:3]);
                    end
                end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/tmr6_dec.sv
module tmr6_dec
    import tmr6_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    logic hi_ok;
    logic [7:0] lo;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign hi_ok = (addr[ADDR_W-1:8] == '0);
            assign lo    = addr[7:0];
        end else begin : g_narrow
            assign hi_ok = 1'b1;
            assign lo    = 8'(addr);
        end
    endgenerate

    assign sel = decode(lo, hi_ok);
endmodule

// File: rtl/tmr6_chan.sv
module tmr6_chan
    import tmr6_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_en,
    input  logic             wr_ctl,
    input  logic             wr_run,
    input  logic             wr_rld,
    input  logic [CTL_W-1:0] wd_ctl,
    input  logic             wd_go,
    input  logic             wd_ld,
    input  logic [CNT_W-1:0] wd_rld,
    output logic [CTL_W-1:0] ctl_q,
    output logic             go_q,
    output logic             ld_pend,
    output logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             evt
);
    logic counting;

    assign counting = go_q && core_en && !ld_pend;
    assign evt      = counting && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            go_q    <= 1'b0;
            ld_pend <= 1'b0;
            rld_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_ctl) ctl_q <= wd_ctl;
            if (wr_rld) rld_q <= wd_rld;
            if (wr_run) begin
                go_q    <= wd_go;
                ld_pend <= wd_ld;
            end else if (ld_pend) begin
                ld_pend <= 1'b0;
            end
            if (ld_pend)
                cnt_q <= rld_q;
            else if (counting)
                cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
        end
    end

    // R4
    load_done_chk: assert property (@(posedge clk) disable iff (rst)
        ld_pend |=> cnt_q == $past(rld_q));

    // R4
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_pend && !wr_run) |=> !ld_pend);

    // R5
    decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (counting && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!counting && !ld_pend) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr6_irq.sv
module tmr6_irq #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         wr_ien,
    input  logic         wr_icr,
    input  logic         wr_cap,
    input  logic [N-1:0] wd,
    output logic [N-1:0] ien_q,
    output logic [N-1:0] icr_q,
    output logic [N-1:0] cap_q,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] clr;

    assign clr   = wr_cap ? wd : '0;
    assign irq_o = cap_q & ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            icr_q <= '0;
            cap_q <= '0;
        end else begin
            if (wr_ien) ien_q <= wd;
            if (wr_icr) icr_q <= wd;
            cap_q <= (cap_q & ~clr) | evt;
        end
    end

    // R7
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((cap_q & $past(evt)) == $past(evt)));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_q != '0) |=> ((cap_q & $past(cap_q & ~clr)) == $past(cap_q & ~clr)));
endmodule

// File: rtl/tmr6_unit.sv
module tmr6_unit
    import tmr6_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NTMR-1:0]   irq_o
);
    sel_t    sel;
    clkctl_t cc_q;
    logic    core_en;

    logic [CTL_W-1:0] ctl_arr [NTMR];
    logic [CNT_W-1:0] rld_arr [NTMR];
    logic [CNT_W-1:0] cnt_arr [NTMR];
    logic [NTMR-1:0]  go_v, ld_v, evt_v;
    logic [NTMR-1:0]  ien_q, icr_q, cap_q;
    logic             wr_glob;

    tmr6_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign core_en = !cc_q.dis && cc_q.susp_rel && cc_q.runm;
    assign wr_glob = bus_wr && (sel.space == SP_CLK);

    always_ff @(posedge clk) begin
        if (rst)
            cc_q <= '0;
        else if (wr_glob)
            cc_q <= '{runm: bus_wdata[8], susp_rel: bus_wdata[4], dis: bus_wdata[0]};
    end

    generate
        for (genvar n = 0; n < NTMR; n++) begin : g_ch
            logic hit;
            assign hit = bus_wr && (sel.space == SP_TMR) && (sel.idx == 3'(n));
            tmr6_chan #(.CNT_W(CNT_W)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .core_en (core_en),
                .wr_ctl  (hit && sel.kind == K_CTL),
                .wr_run  (hit && sel.kind == K_RUN),
                .wr_rld  (hit && sel.kind == K_RLD),
                .wd_ctl  (bus_wdata[CTL_W-1:0]),
                .wd_go   (bus_wdata[0]),
                .wd_ld   (bus_wdata[2]),
                .wd_rld  (bus_wdata[CNT_W-1:0]),
                .ctl_q   (ctl_arr[n]),
                .go_q    (go_v[n]),
                .ld_pend (ld_v[n]),
                .rld_q   (rld_arr[n]),
                .cnt_q   (cnt_arr[n]),
                .evt     (evt_v[n])
            );
        end
    endgenerate

    tmr6_irq #(.N(NTMR)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_v),
        .wr_ien (bus_wr && sel.space == SP_IEN),
        .wr_icr (bus_wr && sel.space == SP_ICR),
        .wr_cap (bus_wr && sel.space == SP_CAP),
        .wd     (bus_wdata[NTMR-1:0]),
        .ien_q  (ien_q),
        .icr_q  (icr_q),
        .cap_q  (cap_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel.space)
            SP_CLK: begin
                bus_rdata[0] = cc_q.dis;
                bus_rdata[4] = cc_q.susp_rel;
                bus_rdata[8] = cc_q.runm;
            end
            SP_ID:  bus_rdata[15:8] = ID_CODE;
            SP_IEN: bus_rdata = 32'(ien_q);
            SP_ICR: bus_rdata = 32'(icr_q);
            SP_CAP: bus_rdata = 32'(cap_q);
            SP_TMR: begin
                case (sel.kind)
                    K_CTL: bus_rdata = 32'(ctl_arr[sel.idx]);
                    K_RUN: begin
                        bus_rdata[0] = go_v[sel.idx];
                        bus_rdata[2] = ld_v[sel.idx];
                    end
                    K_RLD: bus_rdata = 32'(rld_arr[sel.idx]);
                    default: bus_rdata = 32'(cnt_arr[sel.idx]);
                endcase
            end
            default: bus_rdata = '0;
        endcase
    end

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_en && ld_v == '0) |=> $stable(cnt_arr[0]) && $stable(cnt_arr[5]));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0 && !(bus_wr && sel.space == SP_IEN)) |=> irq_o == '0);
endmodule

// File: tb/sim_tmr6_unit.sv
module sim_tmr6_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [5:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tmr6_unit u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] tb_base(int n);
        return 8'((n / 2) * 32 + 16 + ((n % 2) * 4));
    endfunction

    function automatic logic [31:0] exp_cnt(int r, int k);
        return 32'(r - (k % (r + 1)));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed_init;
        seed_init = $urandom(32'd4711);
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        tick(3);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); check("R1 clkctl", v, 0);
        rd(8'hFC, v); check("R1 capture", v, 0);
        rd(8'hF4, v); check("R1 enable", v, 0);
        check("R1 irq", 32'(irq_o), 0);
        rd(tb_base(3) + 8'h18, v); check("R1 count", v, 0);
        rd(tb_base(5) + 8'h08, v); check("R1 run", v, 0);

        // R10 identification
        rd(8'h08, v); check("R10 id", v, 32'h0000_5900);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); check("R10 id write ignored", v, 32'h0000_5900);

        // R2 unmapped offsets
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, v); check("R2 unmapped 04", v, 0);
        rd(8'h70, v); check("R2 unmapped 70", v, 0);
        rd(8'h12, v); check("R2 misaligned", v, 0);

        // R2 map: distinct reload per timer
        for (int n = 0; n < 6; n++) wr(tb_base(n) + 8'h10, 32'h100 + n);
        for (int n = 0; n < 6; n++) begin
            rd(tb_base(n) + 8'h10, v); check("R2 reload map", v, 32'h100 + n);
        end

        // R9 control word storage, interrupt-control storage
        wr(tb_base(3), 32'h0000_05C4);
        rd(tb_base(3), v); check("R9 ctl readback", v, 32'h5C4);
        rd(tb_base(2), v); check("R9 ctl neighbour", v, 0);
        wr(8'hF8, 32'h2A);
        rd(8'hF8, v); check("R9 icr readback", v, 32'h2A);

        // R3 gating: suspend released but no run mode
        wr(8'h00, 32'h0000_0010);
        rd(8'h00, v); check("R3 clkctl readback", v, 32'h10);
        wr(tb_base(0) + 8'h10, 5);
        wr(tb_base(0) + 8'h08, 5);
        tick(5);
        rd(tb_base(0) + 8'h18, v); check("R4 load while gated", v, 5);
        rd(tb_base(0) + 8'h08, v); check("R4 load bit clears", v, 1);
        wr(8'h00, 32'h0000_0111);
        tick(3);
        rd(tb_base(0) + 8'h18, v); check("R3 disabled holds", v, 5);
        wr(8'h00, 32'h0000_0110);
        tick(3);
        rd(tb_base(0) + 8'h18, v); check("R3 counts when enabled", v, 2);

        // R6 stop
        wr(tb_base(0) + 8'h08, 0);
        tick(4);
        rd(tb_base(0) + 8'h18, v); check("R6 stopped count", v, 1);
        rd(tb_base(0) + 8'h08, v); check("R6 run reads zero", v, 0);

        // R9 count read-only
        wr(tb_base(0) + 8'h18, 7);
        rd(tb_base(0) + 8'h18, v); check("R9 count read-only", v, 1);

        // R7 clear colliding with expiry (timer 1, reload 1)
        wr(8'hFC, 32'hFF);
        wr(tb_base(1) + 8'h10, 1);
        wr(tb_base(1) + 8'h08, 5);   // E0
        wr(8'hFC, 32'h02);           // E1 load
        tick(1);                     // E2 count 1->0
        wr(8'hFC, 32'h02);           // E3 expiry + clear
        rd(8'hFC, v); check("R7 expiry beats clear", v & 32'h02, 32'h02);
        wr(8'hFC, 32'h02);           // E4 no expiry
        rd(8'hFC, v); check("R7 write one clears", v & 32'h02, 0);
        wr(tb_base(1) + 8'h08, 0);
        wr(8'hFC, 32'hFF);
        rd(8'hFC, v); check("R7 clear all", v, 0);

        // R5 / R8 random trials, first trial forced to reload 0
        for (int t = 0; t < 40; t++) begin
            int n, r, k, en;
            logic [31:0] ec;
            n  = (t == 0) ? 4 : int'($urandom % 6);
            r  = (t == 0) ? 0 : int'($urandom % 24);
            k  = (t == 0) ? 3 : int'($urandom % 50);
            en = (t == 0) ? 6'h3F : int'($urandom % 64);
            wr(8'hF4, 32'(en));
            wr(8'hFC, 32'hFF);
            wr(tb_base(n) + 8'h10, 32'(r));
            wr(tb_base(n) + 8'h08, 5);
            tick(1 + k);
            rd(tb_base(n) + 8'h18, v); check("R5 count value", v, exp_cnt(r, k));
            ec = ((k / (r + 1)) > 0) ? (32'd1 << n) : 32'd0;
            rd(8'hFC, v); check("R5 capture", v, ec);
            check("R8 irq gating", 32'(irq_o), ec & 32'(en));
            wr(tb_base(n) + 8'h08, 0);
        end

        // R8 mask all while capture pending
        wr(8'hFC, 32'hFF);
        wr(tb_base(2) + 8'h10, 0);
        wr(tb_base(2) + 8'h08, 5);
        tick(3);
        wr(tb_base(2) + 8'h08, 0);
        wr(8'hF4, 0);
        rd(8'hFC, v); check("R8 pending", v, 32'h04);
        check("R8 zero mask", 32'(irq_o), 0);
        wr(8'hF4, 32'h04);
        check("R8 unmasked", 32'(irq_o), 32'h04);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule